// File: doc/BRIEF.md
# UART Receive Descriptor Ring Engine

This block sits between a UART character receiver and buffer memory. It holds a small ring of receive descriptors. Each descriptor carries four flags (empty, wrap, interrupt, continuous), a maximum length, a buffer base address and a received count. Every character that arrives is turned into a write request at the next free position of the current buffer. The engine closes a buffer when it is full, or when the line has stayed idle for a programmed number of character times. On close it writes the received count back into the descriptor, hands the buffer over by clearing its empty flag, raises an interrupt if the descriptor asks for one, and moves on around the ring.

Software arms descriptors through a one-cycle arm port and reads a descriptor's empty flag and count through a combinational read port. The environment supplies a one-cycle tick per character time, which drives the idle timeout. The engine leaves reset in hunt mode and does nothing until a character arrives with reception enabled.

Top module: `uart_rx_ring`

## Requirements
- R1: After reset the engine is hunting (`hunting`=1), `overrun`, `wr_valid` and `irq` are 0, and every descriptor reads back empty flag 0 and count 0.
- R2: While hunting with `enable`=1, `char_tick` has no effect. The first `rx_valid` leaves hunt mode (`hunting`=0 one cycle later), and that character is handled like any other.
- R3: A character that arrives while the current descriptor's empty flag is 1 produces `wr_valid`=1 in the next cycle, with `wr_data` equal to the character and `wr_addr` equal to the buffer base plus the number of bytes already in that buffer.
- R4: When the byte count of the current buffer reaches its maximum length (1 or more), the buffer closes in that same cycle. The descriptor count becomes the maximum length and the empty flag becomes 0. Both changes are visible through the read port one cycle after the character.
- R5: A close pulses `irq` for one cycle, with `irq_idx` equal to the closed descriptor index, only when that descriptor's interrupt flag is 1. Otherwise `irq` stays 0.
- R6: A close of a descriptor whose continuous flag is 1 updates its count but leaves its empty flag at 1. The next time the ring reaches it, writes start again at its base address.
- R7: After a close the ring index advances by one. It returns to 0 after a descriptor whose wrap flag is 1, and after the last descriptor.
- R8: Each accepted character reloads an idle counter from `max_idle`. Each `char_tick` while running decrements a nonzero counter. The step to zero closes the current buffer with its partial count if that buffer holds at least one byte. `max_idle`=0 disables the timeout.
- R9: A character that arrives while the current descriptor's empty flag is 0 is dropped (no `wr_valid`), and `overrun` goes to 1 and stays 1 until reset. Storing resumes at that descriptor once it is re-armed.
- R10: With `enable`=0 the engine returns to hunting one cycle later and ignores `rx_valid`. A partly filled buffer stays open, and after re-enabling the next character is written at base plus the bytes already held.
- R11: An arm pulse writes the flags, length and base of descriptor `arm_idx` and sets its count to 0. If an arm and a close hit the same descriptor in the same cycle, the arm takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Reception enable |
| max_idle | input | IDLE_W | Idle timeout in character times, 0 = off |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| char_tick | input | 1 | One pulse per character time |
| arm_valid | input | 1 | Descriptor arm strobe |
| arm_idx | input | IDX_W | Descriptor to arm |
| arm_empty | input | 1 | Empty flag to write |
| arm_wrap | input | 1 | Wrap flag to write |
| arm_irq | input | 1 | Interrupt flag to write |
| arm_cont | input | 1 | Continuous flag to write |
| arm_len | input | LEN_W | Maximum buffer length |
| arm_ptr | input | ADDR_W | Buffer base address |
| rd_idx | input | IDX_W | Descriptor to read back |
| rd_empty | output | 1 | Empty flag of `rd_idx` |
| rd_count | output | LEN_W | Received count of `rd_idx` |
| wr_valid | output | 1 | Buffer write request |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | DATA_W | Buffer write data |
| irq | output | 1 | Close interrupt pulse |
| irq_idx | output | IDX_W | Descriptor that raised `irq` |
| overrun | output | 1 | Sticky dropped-character flag |
| hunting | output | 1 | Engine is in hunt mode |

## Verification
The write request, the interrupt pulse, the overrun flag and the descriptor write-back all register the cycle that carries the character or tick. Each is therefore due exactly one clock after that stimulus. The `hunting` change after `enable` falls is also due one clock later. The bench drives each stimulus for one cycle starting at a falling edge and samples every result at the next falling edge. The read port is combinational, so it is sampled in that same window after `rd_idx` settles. For every character and tick, the bench updates an arithmetic model of ring index, fill, idle count and descriptor flags, then compares all outputs in that window. Idle expiry is therefore pinned to the exact tick.

// File: rtl/uart_rx_ring_pkg.sv
package uart_rx_ring_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic e;
        logic w;
        logic i;
        logic cm;
    } desc_flags_t;

endpackage

// File: rtl/uart_rx_ring_idle.sv
module uart_rx_ring_idle #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] max_idle,
    input  logic              reload,
    input  logic              tick_en,
    output logic              expire
);
    logic [IDLE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload)
            cnt_d = max_idle;
        else if (tick_en && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    assign expire = tick_en && !reload && (cnt_q == IDLE_W'(1)) && (max_idle != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_rx_ring_table.sv
module uart_rx_ring_table
    import uart_rx_ring_pkg::*;
#(
    parameter int NDESC  = 4,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_en,
    input  logic [IDX_W-1:0]  arm_idx,
    input  desc_flags_t       arm_flags,
    input  logic [LEN_W-1:0]  arm_len,
    input  logic [ADDR_W-1:0] arm_ptr,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [LEN_W-1:0]  upd_cnt,
    input  logic              upd_clear_e,
    input  logic [IDX_W-1:0]  cur_idx,
    output desc_flags_t       cur_flags,
    output logic [LEN_W-1:0]  cur_len,
    output logic [ADDR_W-1:0] cur_ptr,
    input  logic [IDX_W-1:0]  rd_idx,
    output desc_flags_t       rd_flags,
    output logic [LEN_W-1:0]  rd_cnt
);
    desc_flags_t       flags_q [NDESC];
    logic [LEN_W-1:0]  len_q   [NDESC];
    logic [ADDR_W-1:0] ptr_q   [NDESC];
    logic [LEN_W-1:0]  cnt_q   [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[g] <= '0;
                len_q[g]   <= '0;
                ptr_q[g]   <= '0;
                cnt_q[g]   <= '0;
            end else if (arm_en && arm_idx == IDX_W'(g)) begin
                flags_q[g] <= arm_flags;
                len_q[g]   <= arm_len;
                ptr_q[g]   <= arm_ptr;
                cnt_q[g]   <= '0;
            end else if (upd_en && upd_idx == IDX_W'(g)) begin
                cnt_q[g] <= upd_cnt;
                if (upd_clear_e) flags_q[g].e <= 1'b0;
            end
        end
    end

    assign cur_flags = flags_q[cur_idx];
    assign cur_len   = len_q[cur_idx];
    assign cur_ptr   = ptr_q[cur_idx];
    assign rd_flags  = flags_q[rd_idx];
    assign rd_cnt    = cnt_q[rd_idx];
endmodule

// File: rtl/uart_rx_ring.sv
module uart_rx_ring
    import uart_rx_ring_pkg::*;
#(
    parameter int NDESC  = 4,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IDLE_W = 16,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [IDLE_W-1:0] max_idle,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              char_tick,
    input  logic              arm_valid,
    input  logic [IDX_W-1:0]  arm_idx,
    input  logic              arm_empty,
    input  logic              arm_wrap,
    input  logic              arm_irq,
    input  logic              arm_cont,
    input  logic [LEN_W-1:0]  arm_len,
    input  logic [ADDR_W-1:0] arm_ptr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_empty,
    output logic [LEN_W-1:0]  rd_count,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic [IDX_W-1:0]  irq_idx,
    output logic              overrun,
    output logic              hunting
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDESC - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  fill;
        logic              ovr;
        logic              wr_valid;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              irq;
        logic [IDX_W-1:0]  irq_idx;
    } eng_t;

    eng_t r_d, r_q;

    desc_flags_t       cur_flags, rd_flags;
    logic [LEN_W-1:0]  cur_len, rd_cnt_w;
    logic [ADDR_W-1:0] cur_ptr;
    logic              upd_en, upd_clear_e, reload, tick_en, expire;
    logic [LEN_W-1:0]  upd_cnt, fill_inc;
    logic              do_close;

    uart_rx_ring_table #(
        .NDESC(NDESC), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .arm_en(arm_valid), .arm_idx(arm_idx),
        .arm_flags('{e: arm_empty, w: arm_wrap, i: arm_irq, cm: arm_cont}),
        .arm_len(arm_len), .arm_ptr(arm_ptr),
        .upd_en(upd_en), .upd_idx(r_q.idx), .upd_cnt(upd_cnt), .upd_clear_e(upd_clear_e),
        .cur_idx(r_q.idx), .cur_flags(cur_flags), .cur_len(cur_len), .cur_ptr(cur_ptr),
        .rd_idx(rd_idx), .rd_flags(rd_flags), .rd_cnt(rd_cnt_w)
    );

    uart_rx_ring_idle #(.IDLE_W(IDLE_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .max_idle(max_idle),
        .reload(reload), .tick_en(tick_en), .expire(expire)
    );

    always_comb begin
        r_d         = r_q;
        r_d.wr_valid = 1'b0;
        r_d.irq      = 1'b0;
        reload      = 1'b0;
        tick_en     = 1'b0;
        do_close    = 1'b0;
        upd_cnt     = r_q.fill;
        fill_inc    = r_q.fill + 1'b1;

        if (!enable) begin
            r_d.st = ST_HUNT;
        end else if (rx_valid) begin
            r_d.st = ST_RUN;
            reload = 1'b1;
            if (cur_flags.e) begin
                r_d.wr_valid = 1'b1;
                r_d.wr_addr  = cur_ptr + ADDR_W'(r_q.fill);
                r_d.wr_data  = rx_data;
                upd_cnt      = fill_inc;
                if (fill_inc == cur_len) do_close = 1'b1;
                else                     r_d.fill = fill_inc;
            end else begin
                r_d.ovr = 1'b1;
            end
        end else if (char_tick && r_q.st == ST_RUN) begin
            tick_en = 1'b1;
            if (expire && r_q.fill != '0) do_close = 1'b1;
        end

        upd_en      = do_close;
        upd_clear_e = do_close && !cur_flags.cm;
        if (do_close) begin
            r_d.irq     = cur_flags.i;
            r_d.irq_idx = r_q.idx;
            r_d.fill    = '0;
            r_d.idx     = (cur_flags.w || r_q.idx == LAST_IDX) ? '0 : r_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_HUNT, default: '0};
        else        r_q <= r_d;
    end

    assign rd_empty = rd_flags.e;
    assign rd_count = rd_cnt_w;
    assign wr_valid = r_q.wr_valid;
    assign wr_addr  = r_q.wr_addr;
    assign wr_data  = r_q.wr_data;
    assign irq      = r_q.irq;
    assign irq_idx  = r_q.irq_idx;
    assign overrun  = r_q.ovr;
    assign hunting  = (r_q.st == ST_HUNT);
endmodule

// File: rtl/uart_rx_ring_chk.sv
module uart_rx_ring_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic rx_valid,
    input logic char_tick,
    input logic wr_valid,
    input logic irq,
    input logic overrun,
    input logic hunting
);
    // R3: a write request only follows an accepted character
    a_r3_write_follows_char: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(rx_valid && enable));

    // R5: an interrupt only follows a character or a character-time tick
    a_r5_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((rx_valid && enable) || char_tick));

    // R9: overrun stays set
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R10: disabling returns to hunt and blocks writes
    a_r10_disable_hunts: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> hunting);
    a_r10_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !wr_valid);

    // R2: hunt mode is left only on a character
    a_r2_hunt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && !rx_valid) |=> hunting);
endmodule

bind uart_rx_ring uart_rx_ring_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid),
    .char_tick(char_tick), .wr_valid(wr_valid), .irq(irq),
    .overrun(overrun), .hunting(hunting)
);

// File: tb/uart_rx_ring_tb.sv
module uart_rx_ring_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] max_idle = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        char_tick = 1'b0;
    logic        arm_valid = 1'b0;
    logic [1:0]  arm_idx = '0;
    logic        arm_empty = 1'b0, arm_wrap = 1'b0, arm_irq = 1'b0, arm_cont = 1'b0;
    logic [7:0]  arm_len = '0;
    logic [15:0] arm_ptr = '0;
    logic [1:0]  rd_idx = '0;
    logic        rd_empty, wr_valid, irq, overrun, hunting;
    logic [7:0]  rd_count, wr_data;
    logic [15:0] wr_addr;
    logic [1:0]  irq_idx;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model of the ring
    bit  m_e[N], m_w[N], m_i[N], m_cm[N];
    int  m_len[N], m_ptr[N], m_cnt[N];
    int  m_idx = 0, m_fill = 0, m_idle = 0, m_max = 0;
    bit  m_ovr = 0, m_hunt = 1, m_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_ring u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .max_idle(max_idle),
        .rx_valid(rx_valid), .rx_data(rx_data), .char_tick(char_tick),
        .arm_valid(arm_valid), .arm_idx(arm_idx), .arm_empty(arm_empty),
        .arm_wrap(arm_wrap), .arm_irq(arm_irq), .arm_cont(arm_cont),
        .arm_len(arm_len), .arm_ptr(arm_ptr), .rd_idx(rd_idx),
        .rd_empty(rd_empty), .rd_count(rd_count), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .irq_idx(irq_idx),
        .overrun(overrun), .hunting(hunting)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic read_desc(input int idx, input string tag);
        rd_idx = idx[1:0];
        #1;
        chk(tag, "rd_empty", rd_empty, m_e[idx]);
        chk(tag, "rd_count", rd_count, m_cnt[idx]);
    endtask

    task automatic arm(input int idx, input bit e, input bit w, input bit i, input bit cm,
                       input int len, input int ptr);
        arm_valid = 1; arm_idx = idx[1:0]; arm_empty = e; arm_wrap = w;
        arm_irq = i; arm_cont = cm; arm_len = len[7:0]; arm_ptr = ptr[15:0];
        @(negedge clk);
        arm_valid = 0;
        m_e[idx] = e; m_w[idx] = w; m_i[idx] = i; m_cm[idx] = cm;
        m_len[idx] = len; m_ptr[idx] = ptr; m_cnt[idx] = 0;
        read_desc(idx, "R11");
    endtask

    // model of a close: fills in the expected interrupt and closed index
    task automatic model_close(output bit ei, output int eidx, output int cidx);
        m_cnt[m_idx] = m_fill;
        if (!m_cm[m_idx]) m_e[m_idx] = 0;
        ei = m_i[m_idx]; eidx = m_idx; cidx = m_idx;
        m_idx = (m_w[m_idx] || m_idx == N-1) ? 0 : m_idx + 1;
        m_fill = 0;
    endtask

    task automatic send(input logic [7:0] b, input string ctag);
        bit ew = 0, ei = 0; int eidx = 0, cidx = -1; int eaddr = 0;
        if (m_en) begin
            m_hunt = 0; m_idle = m_max;
            if (m_e[m_idx]) begin
                ew = 1; eaddr = (m_ptr[m_idx] + m_fill) & 16'hffff;
                m_fill++;
                if (m_fill == m_len[m_idx]) model_close(ei, eidx, cidx);
            end else m_ovr = 1;
        end
        rx_valid = 1; rx_data = b;
        @(negedge clk);
        rx_valid = 0;
        chk("R3 R10", "wr_valid", wr_valid, ew);
        if (ew) begin
            chk("R3 R7", "wr_addr", wr_addr, eaddr);
            chk("R3", "wr_data", wr_data, b);
        end
        chk("R5", "irq", irq, ei);
        if (ei) chk("R5", "irq_idx", irq_idx, eidx);
        chk("R9", "overrun", overrun, m_ovr);
        chk("R2", "hunting", hunting, m_hunt);
        if (cidx >= 0) read_desc(cidx, ctag);
    endtask

    task automatic tick(input string tag);
        bit ei = 0; int eidx = 0, cidx = -1;
        if (m_en && !m_hunt && m_idle != 0) begin
            m_idle--;
            if (m_idle == 0 && m_fill > 0 && m_max != 0) model_close(ei, eidx, cidx);
        end
        char_tick = 1;
        @(negedge clk);
        char_tick = 0;
        chk(tag, "irq after tick", irq, ei);
        chk(tag, "wr_valid after tick", wr_valid, 0);
        if (cidx >= 0) read_desc(cidx, tag);
        else read_desc(m_idx, tag);
    endtask

    task automatic set_en(input bit e);
        enable = e; m_en = e;
        if (!e) m_hunt = 1;
        @(negedge clk);
        chk("R10", "hunting", hunting, m_hunt);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            m_e[k] = 0; m_w[k] = 0; m_i[k] = 0; m_cm[k] = 0;
            m_len[k] = 0; m_ptr[k] = 0; m_cnt[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "hunting", hunting, 1);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "wr_valid", wr_valid, 0);
        chk("R1", "irq", irq, 0);
        for (int k = 0; k < N; k++) read_desc(k, "R1");

        // ring of three, last one wraps
        arm(0, 1, 0, 1, 0, 3, 16'h0100);
        arm(1, 1, 0, 0, 0, 2, 16'h0200);
        arm(2, 1, 1, 1, 0, 1, 16'h0300);
        set_en(1);
        // R2: ticks while hunting do nothing
        tick("R2");
        tick("R2");
        chk("R2", "hunting before char", hunting, 1);
        // R3 R4 R5 R7: fill the ring, the seventh byte overruns (R9)
        for (int n = 0; n < 7; n++) send(8'h10 + 8'(n), "R4");
        send(8'h55, "R9");
        // R9: re-arm and storing resumes at descriptor 0
        arm(0, 1, 0, 0, 1, 2, 16'h0400);
        send(8'h61, "R6");
        send(8'h62, "R6");
        arm(1, 1, 0, 1, 0, 2, 16'h0500);
        arm(2, 1, 1, 0, 0, 1, 16'h0600);
        send(8'h63, "R4");
        send(8'h64, "R4");
        send(8'h65, "R7");
        // R6: continuous descriptor reached again, overwritten from its base
        send(8'h66, "R6");

        // R8: idle timeout with partial fill
        max_idle = 16'd3; m_max = 3;
        tick("R8");
        send(8'h71, "R8");
        send(8'h72, "R8");
        arm(0, 1, 0, 1, 0, 5, 16'h0700);
        send(8'h73, "R8");
        send(8'h74, "R8");
        for (int t = 0; t < 4; t++) tick("R8");
        // R8: sweep of timeout values
        for (int mi = 1; mi <= 4; mi++) begin
            max_idle = mi[15:0]; m_max = mi;
            arm(m_idx, 1, 0, 1, 0, 8, 16'h0800 + 16'(mi * 16));
            send(8'h80 + 8'(mi), "R8");
            for (int t = 0; t < mi + 1; t++) tick("R8");
        end
        // R8: zero disables
        max_idle = 16'd0; m_max = 0;
        arm(m_idx, 1, 0, 1, 0, 4, 16'h0900);
        send(8'h90, "R8");
        for (int t = 0; t < 5; t++) tick("R8");

        // R10: disable keeps partial buffer open
        set_en(0);
        send(8'h91, "R10");
        tick("R10");
        set_en(1);
        send(8'h92, "R10");
        send(8'h93, "R10");
        send(8'h94, "R4");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule